// File: doc/BRIEF.md
# Tuner Synthesiser I2C Control Slave

This block is the serial control front end of a frequency synthesiser used in tuner front ends. It watches an I2C bus on two open-drain lines that are sampled by the system clock. Write transfers program the synthesiser. Read transfers return a status byte. The block drives only the register-level controls of the divider and loop, plus a pull-down enable for SDA. The prescaler, the divider, the charge pump, the port drivers and the ADC all sit outside it.

In a write transfer, the first bit of each data byte chooses what the byte is. A leading 0 starts a division-ratio pair. That byte carries the upper seven ratio bits, and the next byte carries the low eight. A leading 1 starts a control pair. That byte carries the loop-control bits, and the next byte carries the port-output byte. Pairs of either kind may follow one another without a new address, until a stop arrives. This lets a host sweep the frequency smoothly.

In a read transfer the block shifts out a status byte. The byte holds a power-on flag, the lock indication and the ADC code. The block keeps sending status bytes for as long as the master acknowledges them.

Top module: `tuner_i2c_slave`

## Requirements
- R1: After reset, ratio_o is 0, all four loop-control outputs are 0, port_on_o is 8'h00 (every port high impedance), and sda_pull_o is 0.
- R2: The slave answers the fixed address 7'b1100001 at all times. It also answers the address picked by addr_sel_i: 0 gives 7'b1100001, 1 gives 7'b1100000, 2 gives 7'b1100010, 3 gives 7'b1100011. Any other address gets no acknowledge, and every byte up to the next start is ignored.
- R3: For a matching address, sda_pull_o pulls SDA low during the ninth clock. In a write transfer, every data byte is acknowledged the same way.
- R4: Take the first data byte after the address, or the first byte after a completed pair. If its bit 7 is 0, it is the upper part of a ratio pair. If its bit 7 is 1, it is a control byte.
- R5: ratio_o is {first byte[6:0], second byte[7:0]}. It changes only when the second byte of the pair has been fully received. A first ratio byte followed by a stop leaves ratio_o unchanged.
- R6: A control byte sets four outputs: cp_high_o from bit 6, test_route_o from bit 5, cp_off_o from bit 4 and amp_off_o from bit 0. Bits 3 to 1 are ignored.
- R7: The byte after a control byte is the port byte: port_on_o[i] is bit i, where 1 means the port is on (low impedance).
- R8: Ratio and control pairs may follow one another in any mix within one transfer. Each completed pair takes effect.
- R9: A byte cut short by a start or a stop is discarded, and every output keeps its value. The pairing of bytes restarts after every start.
- R10: The status byte is {POR, lock, 3'b000, adc[2:0]}, sent MSB first. It is captured when each status byte begins.
- R11: After a status byte, the slave sends another one if the master acknowledges. If the master does not acknowledge, the slave releases the bus.
- R12: POR is 1 after reset and is set by pwr_fail_i. It clears only when a read transfer with a matching address ends with a stop. A repeated start does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_sel_i | input | 2 | Selects the second answered address |
| pwr_fail_i | input | 1 | Supply-fail indication; sets POR |
| lock_i | input | 1 | Loop lock indication (1 = locked) |
| adc_i | input | 3 | ADC code reported in status |
| ratio_o | output | 15 | Division ratio for the divider |
| cp_high_o | output | 1 | Charge pump high current select |
| test_route_o | output | 1 | Routes comparator inputs to test ports |
| cp_off_o | output | 1 | Charge pump disable |
| amp_off_o | output | 1 | Drive amplifier off |
| port_on_o | output | 8 | Port outputs, 1 = on |

## Verification
The bench goes after the pairing of bytes at its edges. It sends a lone ratio byte followed by a stop, which would leak half a ratio if the low byte were not held back. It then sends a control byte in a fresh transfer, which would be taken as a ratio low byte if the pairing did not restart on a start. Bytes cut short by a stop or by a repeated start must leave every output as it was; a design that commits partial shifts would corrupt the registers. The POR flag is checked across a read ended by a repeated start, which must not clear it. A status change during a multi-byte read must show up in the next byte, which catches a design that captures status only once per transfer. Wrong addresses must draw neither an acknowledge nor a register change, for each select value.

// File: rtl/tsyn_pkg.sv
`timescale 1ns/1ps
package tsyn_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 15;
  localparam int HI_W    = RATIO_W - BYTE_W;
  localparam int ADC_W   = 3;
  localparam int ADDR_W  = 7;
  localparam int SEL_W   = 2;
  localparam int CNT_W   = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_ADDR, BUS_WDATA, BUS_SACK, BUS_RDATA, BUS_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    SEQ_FIRST, SEQ_LO, SEQ_PORT
  } seq_e;

  typedef struct packed {
    logic cp_high;
    logic test_route;
    logic cp_off;
    logic amp_off;
  } loop_ctl_t;

  function automatic logic [ADDR_W-1:0] pick_addr(
    input logic [ADDR_W-1:0] fixed_addr,
    input logic [ADDR_W-3:0] base,
    input logic [SEL_W-1:0]  sel
  );
    logic [ADDR_W-1:0] a;
    case (sel)
      2'd0:    a = fixed_addr;
      2'd1:    a = {base, 2'b00};
      2'd2:    a = {base, 2'b10};
      default: a = {base, 2'b11};
    endcase
    return a;
  endfunction
endpackage

// File: rtl/tsyn_sync.sv
`timescale 1ns/1ps
module tsyn_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] q_r;
    if (s == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = g_stage[s-1].q_r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RST_VAL;
      else        q_r <= src;
    end
  end

  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/tsyn_bus_engine.sv
`timescale 1ns/1ps
module tsyn_bus_engine
  import tsyn_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIXED_ADDR = 7'b1100001,
  parameter logic [ADDR_W-3:0] SEL_BASE   = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] status,
  output logic              sda_pull,
  output logic              byte_evt,
  output logic [BYTE_W-1:0] byte_data,
  output logic              frame_start,
  output logic              read_stop
);
  bus_st_e           st_q, st_d;
  logic              scl_q, sda_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;

  logic start_det, stop_det, scl_rise, scl_fall, addr_ok;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign addr_ok   = (sh_q[BYTE_W-1:1] == FIXED_ADDR) ||
                     (sh_q[BYTE_W-1:1] == pick_addr(FIXED_ADDR, SEL_BASE, addr_sel));

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    full_d      = full_q;
    sh_d        = sh_q;
    pull_d      = pull_q;
    rd_d        = rd_q;
    mack_d      = mack_q;
    byte_evt    = 1'b0;
    frame_start = 1'b0;
    read_stop   = 1'b0;
    if (stop_det) begin
      st_d      = BUS_IDLE;
      pull_d    = 1'b0;
      read_stop = rd_q;
      rd_d      = 1'b0;
    end else if (start_det) begin
      st_d        = BUS_ADDR;
      cnt_d       = '0;
      full_d      = 1'b0;
      pull_d      = 1'b0;
      rd_d        = 1'b0;
      frame_start = 1'b1;
    end else begin
      case (st_q)
        BUS_ADDR, BUS_WDATA: begin
          if (scl_rise && !full_q) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + CNT_W'(1);
            if (cnt_q == LAST_BIT) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            cnt_d  = '0;
            if (st_q == BUS_ADDR) begin
              if (addr_ok) begin
                pull_d = 1'b1;
                rd_d   = sh_q[0];
                st_d   = BUS_SACK;
              end else begin
                st_d = BUS_IDLE;
              end
            end else begin
              byte_evt = 1'b1;
              pull_d   = 1'b1;
              st_d     = BUS_SACK;
            end
          end
        end
        BUS_SACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              sh_d   = status;
              pull_d = ~status[BYTE_W-1];
              st_d   = BUS_RDATA;
            end else begin
              pull_d = 1'b0;
              st_d   = BUS_WDATA;
            end
          end
        end
        BUS_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              pull_d = 1'b0;
              st_d   = BUS_MACK;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
              cnt_d  = cnt_q + CNT_W'(1);
            end
          end
        end
        BUS_MACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d   = status;
              pull_d = ~status[BYTE_W-1];
              cnt_d  = '0;
              st_d   = BUS_RDATA;
            end else begin
              st_d = BUS_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUS_IDLE;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      cnt_q  <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      pull_q <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      pull_q <= pull_d;
      rd_q   <= rd_d;
      mack_q <= mack_d;
    end
  end

  assign sda_pull  = pull_q;
  assign byte_data = sh_q;

  // R3
  pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> $past(scl_fall));

  // R3
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !pull_q);

  // R2
  addr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BUS_ADDR && full_q && scl_fall && !start_det && !stop_det && !addr_ok)
      |=> (!pull_q && st_q == BUS_IDLE));
endmodule

// File: rtl/tsyn_reg_file.sv
`timescale 1ns/1ps
module tsyn_reg_file
  import tsyn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               byte_evt,
  input  logic [BYTE_W-1:0]  byte_data,
  input  logic               read_stop,
  input  logic               pwr_fail,
  input  logic               lock,
  input  logic [ADC_W-1:0]   adc,
  output logic [RATIO_W-1:0] ratio,
  output loop_ctl_t          ctl,
  output logic [BYTE_W-1:0]  port_on,
  output logic [BYTE_W-1:0]  status
);
  seq_e               seq_q, seq_d;
  logic [HI_W-1:0]    hi_q, hi_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  loop_ctl_t          ctl_q, ctl_d;
  logic [BYTE_W-1:0]  port_q, port_d;
  logic               por_q, por_d;

  always_comb begin
    seq_d   = seq_q;
    hi_d    = hi_q;
    ratio_d = ratio_q;
    ctl_d   = ctl_q;
    port_d  = port_q;
    if (frame_start) begin
      seq_d = SEQ_FIRST;
    end else if (byte_evt) begin
      case (seq_q)
        SEQ_FIRST: begin
          if (!byte_data[BYTE_W-1]) begin
            hi_d  = byte_data[HI_W-1:0];
            seq_d = SEQ_LO;
          end else begin
            ctl_d.cp_high    = byte_data[6];
            ctl_d.test_route = byte_data[5];
            ctl_d.cp_off     = byte_data[4];
            ctl_d.amp_off    = byte_data[0];
            seq_d            = SEQ_PORT;
          end
        end
        SEQ_LO: begin
          ratio_d = {hi_q, byte_data};
          seq_d   = SEQ_FIRST;
        end
        SEQ_PORT: begin
          port_d = byte_data;
          seq_d  = SEQ_FIRST;
        end
        default: seq_d = SEQ_FIRST;
      endcase
    end
    if (pwr_fail)       por_d = 1'b1;
    else if (read_stop) por_d = 1'b0;
    else                por_d = por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= SEQ_FIRST;
      hi_q    <= '0;
      ratio_q <= '0;
      ctl_q   <= '0;
      port_q  <= '0;
      por_q   <= 1'b1;
    end else begin
      seq_q   <= seq_d;
      hi_q    <= hi_d;
      ratio_q <= ratio_d;
      ctl_q   <= ctl_d;
      port_q  <= port_d;
      por_q   <= por_d;
    end
  end

  assign ratio   = ratio_q;
  assign ctl     = ctl_q;
  assign port_on = port_q;
  assign status  = {por_q, lock, 3'b000, adc};

  // R5
  ratio_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(byte_evt && !frame_start && seq_q == SEQ_LO));

  // R7
  port_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_q) |-> $past(byte_evt && !frame_start && seq_q == SEQ_PORT));

  // R12
  por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> por_q);

  // R12
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(read_stop));
endmodule

// File: rtl/tuner_i2c_slave.sv
`timescale 1ns/1ps
module tuner_i2c_slave
  import tsyn_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FIXED_ADDR = 7'b1100001,
  parameter logic [ADDR_W-3:0] SEL_BASE   = 5'b11000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [SEL_W-1:0]   addr_sel_i,
  input  logic               pwr_fail_i,
  input  logic               lock_i,
  input  logic [ADC_W-1:0]   adc_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               cp_high_o,
  output logic               test_route_o,
  output logic               cp_off_o,
  output logic               amp_off_o,
  output logic [BYTE_W-1:0]  port_on_o
);
  localparam int STAT_IN_W = ADC_W + 2;

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [1:0]           bus_s;
  logic [STAT_IN_W-1:0] stat_s;

  tsyn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_int_n), .d({scl_i, sda_i}), .q(bus_s)
  );

  tsyn_sync #(.WIDTH(STAT_IN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_stat_sync (
    .clk(clk), .rst_n(rst_int_n), .d({pwr_fail_i, lock_i, adc_i}), .q(stat_s)
  );

  logic              byte_evt, frame_start, read_stop;
  logic [BYTE_W-1:0] byte_data, status;
  loop_ctl_t         ctl;

  tsyn_bus_engine #(.FIXED_ADDR(FIXED_ADDR), .SEL_BASE(SEL_BASE)) u_engine (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_s      (bus_s[1]),
    .sda_s      (bus_s[0]),
    .addr_sel   (addr_sel_i),
    .status     (status),
    .sda_pull   (sda_pull_o),
    .byte_evt   (byte_evt),
    .byte_data  (byte_data),
    .frame_start(frame_start),
    .read_stop  (read_stop)
  );

  tsyn_reg_file u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_start(frame_start),
    .byte_evt   (byte_evt),
    .byte_data  (byte_data),
    .read_stop  (read_stop),
    .pwr_fail   (stat_s[STAT_IN_W-1]),
    .lock       (stat_s[STAT_IN_W-2]),
    .adc        (stat_s[ADC_W-1:0]),
    .ratio      (ratio_o),
    .ctl        (ctl),
    .port_on    (port_on_o),
    .status     (status)
  );

  assign cp_high_o    = ctl.cp_high;
  assign test_route_o = ctl.test_route;
  assign cp_off_o     = ctl.cp_off;
  assign amp_off_o    = ctl.amp_off;
endmodule

// File: tb/tuner_i2c_slave_tb.sv
`timescale 1ns/1ps
module tuner_i2c_slave_tb;
  localparam int QTR = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_pull;
  logic        sda_line;
  logic [1:0]  addr_sel = 2'd0;
  logic        pwr_fail = 1'b0;
  logic        lock = 1'b0;
  logic [2:0]  adc = 3'd0;
  logic [14:0] ratio;
  logic        cp_high, test_route, cp_off, amp_off;
  logic [7:0]  port_on;

  int n_chk  = 0;
  int n_fail = 0;

  logic [14:0] exp_ratio;
  logic [3:0]  exp_ctl;
  logic [7:0]  exp_port;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  tuner_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(addr_sel), .pwr_fail_i(pwr_fail), .lock_i(lock), .adc_i(adc),
    .ratio_o(ratio), .cp_high_o(cp_high), .test_route_o(test_route),
    .cp_off_o(cp_off), .amp_off_o(amp_off), .port_on_o(port_on)
  );

  typedef struct packed {
    logic [7:0]  first;
    logic [7:0]  second;
    logic [14:0] ratio;
    logic [3:0]  ctl;
    logic [7:0]  port;
  } vec_t;

  // ctl order {cp_high, test_route, cp_off, amp_off}; values follow R5, R6, R7
  localparam vec_t VECS [6] = '{
    '{8'h12, 8'h34, 15'h1234, 4'b0000, 8'h00},
    '{8'hC1, 8'hA5, 15'h1234, 4'b1001, 8'hA5},
    '{8'h7F, 8'hFF, 15'h7FFF, 4'b1001, 8'hA5},
    '{8'hB0, 8'h3C, 15'h7FFF, 4'b0110, 8'h3C},
    '{8'h00, 8'h01, 15'h0001, 4'b0110, 8'h3C},
    '{8'hFF, 8'h00, 15'h0001, 4'b1111, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait(); qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    acked = ~sda_line;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
      b[i] = sda_line;
      qwait(); scl_m = 1'b0; qwait();
    end
    put_bit(~give_ack);
    sda_m = 1'b1;
  endtask

  task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    put_byte(b, a);
    check(tag, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic check_outs(input string tag);
    qwait();
    check({tag, " ratio"}, {17'd0, ratio}, {17'd0, exp_ratio});
    check({tag, " ctl"}, {28'd0, cp_high, test_route, cp_off, amp_off}, {28'd0, exp_ctl});
    check({tag, " port"}, {24'd0, port_on}, {24'd0, exp_port});
  endtask

  task automatic read_one(input logic [7:0] exp_stat, input string tag);
    logic [7:0] s;
    bus_start();
    wbyte(8'hC3, 1'b1, {tag, " R3 read addr ack"});
    get_byte(1'b0, s);
    check({tag, " R10 status"}, {24'd0, s}, {24'd0, exp_stat});
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog R1..R12 run actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] s;
    exp_ratio = '0; exp_ctl = '0; exp_port = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1 reset state
    check("R1 reset pull", {31'd0, sda_pull}, 32'd0);
    check_outs("R1 reset");

    // R10 R11 R12: status after reset, multi-byte read, adc change between bytes
    lock = 1'b1; adc = 3'b101;
    qwait();
    bus_start();
    wbyte(8'hC3, 1'b1, "R3 read addr ack");
    adc = 3'b010;
    get_byte(1'b1, s);
    check("R10 R12 first status POR set", {24'd0, s}, 32'hC5);
    get_byte(1'b0, s);
    check("R11 second status recaptured", {24'd0, s}, 32'hC2);
    bus_stop();
    read_one(8'h42, "R12 POR cleared by read stop");

    // R4 R5 R6 R7: vector table, one pair per transfer
    foreach (VECS[k]) begin
      bus_start();
      wbyte(8'hC2, 1'b1, "R3 write addr ack");
      wbyte(VECS[k].first, 1'b1, "R3 data ack first");
      wbyte(VECS[k].second, 1'b1, "R3 data ack second");
      bus_stop();
      exp_ratio = VECS[k].ratio; exp_ctl = VECS[k].ctl; exp_port = VECS[k].port;
      check_outs($sformatf("R4 R5 R6 R7 vec%0d", k));
    end

    // R8 streaming mixed pairs in one transfer
    bus_start();
    wbyte(8'hC2, 1'b1, "R8 addr ack");
    wbyte(8'h05, 1'b1, "R8 ack");
    wbyte(8'h06, 1'b1, "R8 ack");
    wbyte(8'h80, 1'b1, "R8 ack");
    wbyte(8'hFF, 1'b1, "R8 ack");
    wbyte(8'h2A, 1'b1, "R8 ack");
    wbyte(8'hAA, 1'b1, "R8 ack");
    bus_stop();
    exp_ratio = 15'h2AAA; exp_ctl = 4'b0000; exp_port = 8'hFF;
    check_outs("R8 stream");

    // R5 lone ratio byte then stop: ratio held
    bus_start();
    wbyte(8'hC2, 1'b1, "R5 addr ack");
    wbyte(8'h11, 1'b1, "R5 ack");
    bus_stop();
    check_outs("R5 lone upper byte");

    // R9 pairing restarts on start: 0x81 is control, 0x0F port
    bus_start();
    wbyte(8'hC2, 1'b1, "R9 addr ack");
    wbyte(8'h81, 1'b1, "R9 ack");
    wbyte(8'h0F, 1'b1, "R9 ack");
    bus_stop();
    exp_ctl = 4'b0001; exp_port = 8'h0F;
    check_outs("R9 pairing restart");

    // R9 partial byte cut by stop
    bus_start();
    wbyte(8'hC2, 1'b1, "R9 addr ack");
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    check_outs("R9 cut by stop");

    // R9 partial byte cut by repeated start
    bus_start();
    wbyte(8'hC2, 1'b1, "R9 addr ack");
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_start();
    wbyte(8'hC2, 1'b1, "R9 readdress ack");
    wbyte(8'h01, 1'b1, "R9 ack");
    wbyte(8'h02, 1'b1, "R9 ack");
    bus_stop();
    exp_ratio = 15'h0102;
    check_outs("R9 cut by start");

    // R2 address selection
    addr_sel = 2'd2;
    qwait();
    bus_start(); wbyte(8'hC4, 1'b1, "R2 sel2 1100010 ack"); bus_stop();
    bus_start(); wbyte(8'hC2, 1'b1, "R2 sel2 fixed ack"); bus_stop();
    bus_start();
    wbyte(8'hC0, 1'b0, "R2 sel2 1100000 no ack");
    wbyte(8'h00, 1'b0, "R2 ignored byte no ack");
    wbyte(8'h55, 1'b0, "R2 ignored byte no ack");
    bus_stop();
    check_outs("R2 ignored write");
    addr_sel = 2'd1;
    qwait();
    bus_start(); wbyte(8'hC0, 1'b1, "R2 sel1 1100000 ack"); bus_stop();
    addr_sel = 2'd3;
    qwait();
    bus_start(); wbyte(8'hC6, 1'b1, "R2 sel3 1100011 ack"); bus_stop();
    bus_start(); wbyte(8'hC4, 1'b0, "R2 sel3 1100010 no ack"); bus_stop();
    bus_start(); wbyte(8'hC1, 1'b0, "R2 sel3 read 1100000 no ack"); bus_stop();
    addr_sel = 2'd0;
    qwait();

    // R12 pwr_fail sets POR; repeated start does not clear it
    pwr_fail = 1'b1; qwait(); pwr_fail = 1'b0; qwait();
    bus_start();
    wbyte(8'hC3, 1'b1, "R12 read addr ack");
    get_byte(1'b0, s);
    check("R12 POR set by pwr_fail", {24'd0, s}, 32'hC2);
    bus_start();
    wbyte(8'hC2, 1'b1, "R12 write after repeated start ack");
    bus_stop();
    read_one(8'hC2, "R12 POR kept after repeated start");
    lock = 1'b0;
    qwait();
    read_one(8'h02, "R12 POR cleared and unlocked");
    check("R3 bus released at end", {31'd0, sda_pull}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule